// File: doc/BRIEF.md
# Two-Way Instruction Cache with Next-Line Prefetch

This block is a read-only instruction store placed between an instruction fetch unit and a slower memory level. The fetch side raises a request with a byte address and, when the 64-byte line holding that address is resident, receives the whole line in the same cycle. When the line is absent, the fetch side stalls. The cache then reads the line from the lower level and installs it in one of two ways of the set that the address selects.

Each demand refill is followed by a second read for the line directly above it, but only when that neighbour is not resident yet. This gives sequential code a head start. The fetch side is released as soon as its own line is in place, even if that second read is still in flight. An invalidate-all pulse empties the whole cache in one cycle and abandons any neighbour read that has not yet been handed to memory.

Top module: `icache_pf`

## Requirements
- R1: A fetch whose line is resident raises `fetch_valid` in the same cycle as `fetch_req`, with `fetch_line` holding that line, and starts no memory read.
- R2: A fetch whose line is absent keeps `fetch_valid` low and issues a memory read whose address is the fetch address with its low 6 bits cleared.
- R3: In the cycle after the demand line arrives, `fetch_valid` is high with that line. This does not wait for the neighbour read, which may still be requested or outstanding.
- R4: After a demand fill, if the next line (line address plus one, byte address plus 64) is absent, a second read for it follows the demand read.
- R5: If that next line is already resident, no second read is made.
- R6: Each set keeps one recency bit, updated on every hit and every fill. A fill goes to an empty way first (way 0 before way 1), and otherwise to the less recently used way. No line is ever held in both ways.
- R7: A fetch of the line currently being read as a neighbour stalls until that read installs the line, and causes no duplicate memory read.
- R8: `inv_all` clears every valid bit in one cycle, so any later fetch misses. If a neighbour read has not yet been accepted by memory, it is withdrawn and never issued.
- R9: Only one memory read is outstanding at a time. An offered read keeps its address until `mem_req_ready` accepts it.
- R10: A line installed by a neighbour read later hits without any memory read.
- R11: The line after the highest line address wraps to line address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_all | input | 1 | Invalidate every line, cancel unissued neighbour read |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_valid | output | 1 | Requested line is present on fetch_line |
| fetch_line | output | 512 | 64-byte line, byte 0 in bits 7:0 |
| mem_req_valid | output | 1 | Line read offered to memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | ADDR_W | 64-byte aligned line address |
| mem_rsp_valid | input | 1 | Line returned in this cycle |
| mem_rsp_line | input | 512 | Returned line data |

## Verification
The assertions assume two things about the environment. First, the fetch unit holds `fetch_addr` steady while `fetch_req` is high and `fetch_valid` is low. Second, memory returns exactly one response for each accepted read and never an unsolicited one. The bench's memory model accepts a read only after it has been offered for a full cycle, and it answers each read once after a fixed latency. The fetch driver changes its address only after the cache has delivered a line. The cancel case raises `inv_all` in the very cycle the neighbour read is first offered, which is the only window in which cancellation is visible.

// File: rtl/icpf_pkg.sv
package icpf_pkg;
  localparam int LINE_BYTES = 64;
  localparam int OFF_W      = 6;
  localparam int LINE_W     = LINE_BYTES * 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DREQ  = 3'd1,
    ST_DWAIT = 3'd2,
    ST_PREQ  = 3'd3,
    ST_PWAIT = 3'd4
  } icpf_state_e;
endpackage

// File: rtl/icpf_tags.sv
module icpf_tags #(
  parameter int SETS  = 512,
  parameter int IDX_W = 9,
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic             a_hit,
  output logic             a_way,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic             b_hit,
  input  logic             use_en,
  input  logic [IDX_W-1:0] use_idx,
  input  logic             use_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             fill_way
);
  logic [1:0]      a_hits;
  logic [1:0]      b_hits;
  logic [1:0]      fill_vld;
  logic [SETS-1:0] lru_q;   // 1: way 1 is the older one

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             wr_here;

    assign wr_here = fill_en && (fill_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else begin
        if (inv_all) vld_q <= '0;
        if (wr_here) vld_q[fill_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_here) tag_q[fill_idx] <= fill_tag;
    end

    assign a_hits[w]   = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
    assign b_hits[w]   = vld_q[b_idx] && (tag_q[b_idx] == b_tag);
    assign fill_vld[w] = vld_q[fill_idx];
  end

  assign a_hit = |a_hits;
  assign a_way = a_hits[1];
  assign b_hit = |b_hits;

  always_comb begin
    if (!fill_vld[0])      fill_way = 1'b0;
    else if (!fill_vld[1]) fill_way = 1'b1;
    else                   fill_way = lru_q[fill_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else begin
      if (use_en)  lru_q[use_idx]  <= ~use_way;
      if (fill_en) lru_q[fill_idx] <= ~fill_way;
    end
  end

  // R6
  a_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(a_hits));

  // R6
  b_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(b_hits));
endmodule

// File: rtl/icpf_data.sv
module icpf_data #(
  parameter int SETS   = 512,
  parameter int IDX_W  = 9,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_way,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_way,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int SLOTS = 2 * SETS;

  logic [LINE_W-1:0] mem_q [SLOTS];

  function automatic logic [IDX_W:0] slot_of(input logic [IDX_W-1:0] idx,
                                             input logic way);
    return {idx, way};
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[slot_of(wr_idx, wr_way)] <= wr_line;
  end

  assign rd_line = mem_q[slot_of(rd_idx, rd_way)];
endmodule

// File: rtl/icpf_ctrl.sv
module icpf_ctrl
  import icpf_pkg::*;
#(
  parameter int LA_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inv_all,
  input  logic            fetch_req,
  input  logic [LA_W-1:0] fetch_la,
  input  logic            fetch_hit,
  input  logic            next_present,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  output logic            mem_req_valid,
  output logic [LA_W-1:0] mem_req_la,
  output logic            fill_en,
  output logic            fill_is_dem,
  output logic [LA_W-1:0] fill_la,
  output logic [LA_W-1:0] dem_la
);
  icpf_state_e     st_q, st_d;
  logic [LA_W-1:0] dem_q, dem_d;
  logic [LA_W-1:0] pf_q, pf_d;
  logic            drop_q, drop_d;

  // named events
  logic dem_miss_evt, pf_cancel_evt, pf_issue_evt;

  function automatic logic [LA_W-1:0] next_line(input logic [LA_W-1:0] la);
    return la + LA_W'(1);
  endfunction

  assign dem_la        = dem_q;
  assign dem_miss_evt  = (st_q == ST_IDLE) && fetch_req && !fetch_hit;
  assign pf_issue_evt  = (st_q == ST_PREQ) && mem_req_ready;
  assign pf_cancel_evt = (st_q == ST_PREQ) && !mem_req_ready && inv_all;

  always_comb begin
    st_d          = st_q;
    dem_d         = dem_q;
    pf_d          = pf_q;
    drop_d        = drop_q;
    mem_req_valid = 1'b0;
    mem_req_la    = dem_q;
    fill_en       = 1'b0;
    fill_is_dem   = 1'b0;
    fill_la       = dem_q;
    case (st_q)
      ST_IDLE: begin
        if (dem_miss_evt) begin
          dem_d = fetch_la;
          st_d  = ST_DREQ;
        end
      end
      ST_DREQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (mem_rsp_valid) begin
          fill_en     = 1'b1;
          fill_is_dem = 1'b1;
          pf_d        = next_line(dem_q);
          st_d        = (next_present && !inv_all) ? ST_IDLE : ST_PREQ;
        end
      end
      ST_PREQ: begin
        mem_req_valid = 1'b1;
        mem_req_la    = pf_q;
        if (pf_issue_evt) begin
          st_d   = ST_PWAIT;
          drop_d = inv_all;
        end else if (pf_cancel_evt) begin
          st_d = ST_IDLE;
        end
      end
      ST_PWAIT: begin
        fill_la = pf_q;
        if (inv_all) drop_d = 1'b1;
        if (mem_rsp_valid) begin
          fill_en = !drop_q && !inv_all;
          drop_d  = 1'b0;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dem_q  <= '0;
      pf_q   <= '0;
      drop_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dem_q  <= dem_d;
      pf_q   <= pf_d;
      drop_q <= drop_d;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !inv_all) |=>
      (mem_req_valid && $stable(mem_req_la)));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (st_q == ST_DWAIT || st_q == ST_PWAIT));

  // R8
  pf_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_cancel_evt |=> !mem_req_valid);
endmodule

// File: rtl/icache_pf.sv
module icache_pf
  import icpf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CAP_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [LINE_W-1:0] fetch_line,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line
);
  localparam int SETS  = CAP_BYTES / (LINE_BYTES * 2);
  localparam int IDX_W = $clog2(SETS);
  localparam int LA_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LA_W - IDX_W;

  function automatic logic [LA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction
  function automatic logic [IDX_W-1:0] set_of(input logic [LA_W-1:0] la);
    return la[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [LA_W-1:0] la);
    return la[LA_W-1:IDX_W];
  endfunction

  logic [LA_W-1:0] fetch_la, dem_la, next_la, fill_la, req_la;
  logic            a_hit, a_way, b_hit, fill_way;
  logic            fill_en, fill_is_dem;

  assign fetch_la     = line_of(fetch_addr);
  assign next_la      = dem_la + LA_W'(1);
  assign fetch_valid  = fetch_req && a_hit;
  assign mem_req_addr = {req_la, {OFF_W{1'b0}}};

  icpf_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_all  (inv_all),
    .a_idx    (set_of(fetch_la)),
    .a_tag    (tag_of(fetch_la)),
    .a_hit    (a_hit),
    .a_way    (a_way),
    .b_idx    (set_of(next_la)),
    .b_tag    (tag_of(next_la)),
    .b_hit    (b_hit),
    .use_en   (fetch_valid),
    .use_idx  (set_of(fetch_la)),
    .use_way  (a_way),
    .fill_en  (fill_en),
    .fill_idx (set_of(fill_la)),
    .fill_tag (tag_of(fill_la)),
    .fill_way (fill_way)
  );

  icpf_data #(.SETS(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_idx  (set_of(fetch_la)),
    .rd_way  (a_way),
    .rd_line (fetch_line),
    .wr_en   (fill_en),
    .wr_idx  (set_of(fill_la)),
    .wr_way  (fill_way),
    .wr_line (mem_rsp_line)
  );

  icpf_ctrl #(.LA_W(LA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .inv_all       (inv_all),
    .fetch_req     (fetch_req),
    .fetch_la      (fetch_la),
    .fetch_hit     (a_hit),
    .next_present  (b_hit),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_la    (req_la),
    .fill_en       (fill_en),
    .fill_is_dem   (fill_is_dem),
    .fill_la       (fill_la),
    .dem_la        (dem_la)
  );

  // R3
  dem_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_is_dem && fetch_req && fetch_la == fill_la) |=>
      (!fetch_req || fetch_valid || fetch_la != $past(fill_la)));

  // R1
  hit_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !mem_req_valid && !mem_rsp_valid) |=> !mem_req_valid);
endmodule

// File: tb/icache_pf_tb.sv
module icache_pf_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inv_all = 1'b0;
  logic         fetch_req = 1'b0;
  logic [31:0]  fetch_addr = '0;
  logic         fetch_valid;
  logic [511:0] fetch_line;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [511:0] mem_rsp_line = '0;

  int checks = 0;
  int errors = 0;
  int n_req = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_pf u_dut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_line(fetch_line),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_line(mem_rsp_line)
  );

  function automatic logic [511:0] pat(input logic [31:0] a);
    logic [511:0] p;
    logic [31:0]  base;
    base = (a >> 6) << 4;
    for (int i = 0; i < 16; i++) p[i*32 +: 32] = (base + 32'(i)) ^ 32'h5A00_0000;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_req(input logic [31:0] a);
    exp_q.push_back(a);
  endtask

  // memory model and request scoreboard monitor
  initial begin
    int cnt = 0;
    bit prev_v = 1'b0;
    logic [31:0] pend = '0;
    logic [31:0] e;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_line  = pat(pend);
        end
      end
      mem_req_ready = prev_v;
      prev_v = mem_req_valid;
      if (mem_req_valid && mem_req_ready) begin
        n_req++;
        check(cnt == 0 && !mem_rsp_valid, "R9", "request while one outstanding",
              512'(cnt), 512'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R4", "unexpected memory read", 512'(mem_req_addr), 512'(0));
        end else begin
          e = exp_q.pop_front();
          check(mem_req_addr == e, "R2/R4", "memory read address",
                512'(mem_req_addr), 512'(e));
        end
        pend = mem_req_addr;
        cnt  = 3;
      end
    end
  end

  // want_hit: 1 expect same-cycle hit, 0 expect stall; pf_busy: -1 ignore
  task automatic fetch(input logic [31:0] a, input int want_hit, input int pf_busy,
                       input bit do_inv, input string req);
    int cyc = 0;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    #1;
    while (!fetch_valid && cyc < 300) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    check(fetch_valid && fetch_line == pat(a), req, "returned line",
          fetch_line, pat(a));
    if (want_hit == 1) check(cyc == 0, req, "hit latency", 512'(cyc), 512'(0));
    if (want_hit == 0) check(cyc > 0, req, "miss stalled", 512'(cyc), 512'(1));
    if (pf_busy >= 0)
      check(mem_req_valid == pf_busy[0], "R3", "neighbour read pending at release",
            512'(mem_req_valid), 512'(pf_busy));
    if (do_inv) inv_all = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    if (do_inv) begin
      inv_all = 1'b0;
      #1;
      check(!mem_req_valid, "R8", "neighbour read withdrawn",
            512'(mem_req_valid), 512'(0));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int base_req;
    repeat (3) @(negedge clk);
    #1;
    check(!fetch_valid, "R1", "reset fetch_valid", 512'(fetch_valid), 512'(0));
    check(!mem_req_valid, "R9", "reset mem_req_valid", 512'(mem_req_valid), 512'(0));
    rst_n = 1'b1;
    idle(2);

    // R2 R3 R4: demand miss then neighbour read, released early
    base_req = n_req;
    expect_req(32'h0000_1200);
    expect_req(32'h0000_1240);
    fetch(32'h0000_1234, 0, 1, 1'b0, "R2");
    // R7: fetch the line being read as neighbour
    fetch(32'h0000_1248, 0, -1, 1'b0, "R7");
    idle(12);
    check(n_req - base_req == 2, "R4", "reads after first miss",
          512'(n_req - base_req), 512'(2));

    // R1 R10
    fetch(32'h0000_1200, 1, 0, 1'b0, "R1");
    fetch(32'h0000_127C, 1, 0, 1'b0, "R10");

    // R5: next line resident
    base_req = n_req;
    expect_req(32'h0000_11C0);
    fetch(32'h0000_11C8, 0, 0, 1'b0, "R5");
    idle(12);
    check(n_req - base_req == 1, "R5", "no neighbour read",
          512'(n_req - base_req), 512'(1));

    // R6: replacement in set 0x48
    expect_req(32'h0000_9200);
    expect_req(32'h0000_9240);
    fetch(32'h0000_9200, 0, 1, 1'b0, "R6");
    idle(12);
    fetch(32'h0000_1200, 1, -1, 1'b0, "R6");
    expect_req(32'h0001_1200);
    expect_req(32'h0001_1240);
    fetch(32'h0001_1204, 0, 1, 1'b0, "R6");
    idle(12);
    fetch(32'h0000_1210, 1, 0, 1'b0, "R6");
    expect_req(32'h0000_9200);
    fetch(32'h0000_9200, 0, 0, 1'b0, "R6");
    idle(12);

    // R8: invalidate all
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    expect_req(32'h0000_1200);
    expect_req(32'h0000_1240);
    fetch(32'h0000_1200, 0, 1, 1'b0, "R8");
    idle(12);
    expect_req(32'h0004_0000);
    fetch(32'h0004_0000, 0, 1, 1'b1, "R8");
    idle(12);
    expect_req(32'h0004_0040);
    expect_req(32'h0004_0080);
    fetch(32'h0004_0040, 0, 1, 1'b0, "R8");
    idle(12);

    // R11: wrap
    expect_req(32'hFFFF_FFC0);
    expect_req(32'h0000_0000);
    fetch(32'hFFFF_FFC4, 0, 1, 1'b0, "R11");
    idle(12);
    fetch(32'h0000_0008, 1, 0, 1'b0, "R11");
    idle(4);

    check(exp_q.size() == 0, "R4", "all expected reads seen",
          512'(exp_q.size()), 512'(0));
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule